// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital half of a successive-approximation analog-to-digital converter. A rising edge on the start input begins a conversion. The block loads a trial code with only its top bit set and drives that code to an external DAC. It then reads a single comparator bit back and settles one bit of the result per clock, from the most significant bit to the least significant bit.

The comparator is expected to report 1 when the DAC level lies below the sampled input. A 1 keeps the bit under test. A 0 drops it. In both cases the next lower bit is raised for the following trial. After the last bit has been decided, the final code is copied to the result port and the done output pulses for one cycle. The result stays on the port until the next conversion finishes.

The done pulse is the valid strobe for the result. There is no ready input, and therefore no back-pressure: the result is held, so a consumer may capture it on the pulse or at any later time before the next pulse. The sample-and-hold, the DAC and the comparator sit outside the block. The width is set by the parameter `RES_BITS`, which defaults to 3.

Top module: `sar_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the trial code, the result code, busy and done to zero.
- R2: When the block is idle and start goes from 0 to 1 between two clock edges, the next edge sets busy and loads the trial code with the MSB set and all other bits clear (100 for 3 bits).
- R3: The comparator is sampled on each clock edge following the presentation of a trial code, and one bit is decided per clock. Done rises exactly `RES_BITS` edges after the loading edge.
- R4: A comparator value of 1 leaves the bit under test set in the next trial code and also sets the next lower bit.
- R5: A comparator value of 0 clears the bit under test in the next trial code and sets the next lower bit.
- R6: On the LSB decision, the comparator value is written into bit 0 and no further bit is raised. The finished code appears on the result port, busy falls, and done is high for exactly one cycle.
- R7: The result port holds its value from the end of one conversion until the end of the next, whatever happens on the comparator or start inputs in between.
- R8: Start is ignored while busy. A start level held high without a new 0-to-1 transition seen while idle does not begin a conversion.
- R9: For 3 bits and an input level of 5, the trial codes are 100, 110 and 101 in turn, and the result is 101.
- R10: With a comparator that reports 1 when the trial code is at or below the input level, every one of the 2^`RES_BITS` input levels converts to a result equal to that level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Conversion request; acts on a 0-to-1 transition while idle |
| cmp_i | input | 1 | Comparator result: 1 means the DAC level is below the input |
| trial_o | output | RES_BITS | Trial code driven to the external DAC |
| code_o | output | RES_BITS | Result of the last finished conversion, held |
| busy_o | output | 1 | High while a conversion is in progress |
| done_o | output | 1 | One-cycle pulse marking a new value on code_o |

## Verification
The level-5 case follows a single keep/drop path in which the decisions alternate, so it separates the rule that keeps a bit from the rule that drops one. Sweeping every input level from 0 to 7 covers every decision path, including the all-ones and all-zeros cases, where only one of the two rules is used. Start pulses during a conversion and a start level held across its end show whether the edge detection is ignored while busy. Changing the input level after a conversion shows whether the held result is disturbed.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } sar_phase_t;

endpackage

// File: rtl/sar_edge_det.sv
module sar_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic rise_o,
  output logic q_o
);

  logic last_q;

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= level_i;
  end

  assign rise_o = level_i & ~last_q;
  assign q_o    = last_q;

endmodule

// File: rtl/sar_bit_step.sv
module sar_bit_step #(
  parameter int W = 3
) (
  input  logic [W-1:0] code_i,
  input  logic [W-1:0] ptr_i,
  input  logic         cmp_i,
  output logic [W-1:0] code_o,
  output logic [W-1:0] ptr_o,
  output logic         last_o
);

  // Per bit: the bit under test takes the comparator value, the bit just
  // below it is raised, every other bit keeps its value.
  for (genvar k = 0; k < W; k++) begin : g_bit
    if (k == W - 1) begin : g_top
      assign code_o[k] = ptr_i[k] ? cmp_i : code_i[k];
    end else begin : g_low
      assign code_o[k] = ptr_i[k]   ? cmp_i :
                         ptr_i[k+1] ? 1'b1  : code_i[k];
    end
  end

  assign ptr_o  = ptr_i >> 1;
  assign last_o = ptr_i[0];

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int RES_BITS = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                cmp_i,
  output logic [RES_BITS-1:0] trial_o,
  output logic [RES_BITS-1:0] code_o,
  output logic                busy_o,
  output logic                done_o
);
  import sar_pkg::*;

  localparam logic [RES_BITS-1:0] TOP_ONLY = {1'b1, {(RES_BITS-1){1'b0}}};

  sar_phase_t          phase_q;
  logic [RES_BITS-1:0] work_q;
  logic [RES_BITS-1:0] ptr_q;
  logic [RES_BITS-1:0] result_q;
  logic                done_q;

  logic                start_rise;
  logic                start_q;
  logic [RES_BITS-1:0] work_nx;
  logic [RES_BITS-1:0] ptr_nx;
  logic                last_bit;

  sar_edge_det u_edge (
    .clk     (clk),
    .rst     (rst),
    .level_i (start_i),
    .rise_o  (start_rise),
    .q_o     (start_q)
  );

  sar_bit_step #(.W(RES_BITS)) u_step (
    .code_i (work_q),
    .ptr_i  (ptr_q),
    .cmp_i  (cmp_i),
    .code_o (work_nx),
    .ptr_o  (ptr_nx),
    .last_o (last_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      work_q   <= '0;
      ptr_q    <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (start_rise) begin
            phase_q <= PH_RUN;
            work_q  <= TOP_ONLY;
            ptr_q   <= TOP_ONLY;
          end
        end
        PH_RUN: begin
          work_q <= work_nx;
          ptr_q  <= ptr_nx;
          if (last_bit) begin
            phase_q  <= PH_IDLE;
            result_q <= work_nx;
            done_q   <= 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign trial_o = work_q;
  assign code_o  = result_q;
  assign busy_o  = (phase_q == PH_RUN);
  assign done_o  = done_q;

endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
  parameter int RES_BITS = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                start_i,
  input logic                cmp_i,
  input logic [RES_BITS-1:0] trial_o,
  input logic [RES_BITS-1:0] code_o,
  input logic                busy_o,
  input logic                done_o,
  input logic [RES_BITS-1:0] ptr_q,
  input logic                start_q
);

  localparam logic [RES_BITS-1:0] TOP_ONLY = {1'b1, {(RES_BITS-1){1'b0}}};

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (trial_o == '0 && code_o == '0 && !busy_o && !done_o));

  p_start_load_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i && !start_q) |=> (busy_o && trial_o == TOP_ONLY));

  p_one_ptr_r3: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> $onehot0(ptr_q) && ptr_q != '0);

  p_keep_bit_r4: assert property (@(posedge clk) disable iff (rst)
    (busy_o && cmp_i && !ptr_q[0]) |=>
      ((trial_o & $past(ptr_q)) != '0) && ((trial_o & ($past(ptr_q) >> 1)) != '0));

  p_drop_bit_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !cmp_i && !ptr_q[0]) |=>
      ((trial_o & $past(ptr_q)) == '0) && ((trial_o & ($past(ptr_q) >> 1)) != '0));

  p_last_bit_r6: assert property (@(posedge clk) disable iff (rst)
    (busy_o && ptr_q[0]) |=> (done_o && !busy_o && code_o == trial_o &&
                              trial_o[0] == $past(cmp_i)));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_hold_code_r7: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && ptr_q[0]) |=> $stable(code_o));

  p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !ptr_q[0]) |=> (busy_o && ptr_q == ($past(ptr_q) >> 1)));

endmodule

bind sar_ctrl sar_ctrl_chk #(.RES_BITS(RES_BITS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .cmp_i   (cmp_i),
  .trial_o (trial_o),
  .code_o  (code_o),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .ptr_q   (ptr_q),
  .start_q (start_q)
);

// File: tb/sim_sar_ctrl.sv
`timescale 1ns/1ps
module sim_sar_ctrl;

  localparam int NB = 3;
  localparam int LEVELS = 1 << NB;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic          cmp_i;
  logic [NB-1:0] trial_o;
  logic [NB-1:0] code_o;
  logic          busy_o;
  logic          done_o;

  int level = 0;
  int n_checks = 0;
  int n_fails = 0;
  int cycles = 0;

  // Reference model state
  int m_trial = 0, m_code = 0, m_bit = 0;
  bit m_busy = 0, m_done = 0, m_prev = 0;

  always #5 clk = ~clk;

  // Comparator model: equality keeps the bit.
  assign cmp_i = (int'(trial_o) <= level);

  sar_ctrl #(.RES_BITS(NB)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .cmp_i(cmp_i),
    .trial_o(trial_o), .code_o(code_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(string req, int actual, int expected);
    n_checks++;
    if (actual != expected) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, actual, expected, cycles);
    end
  endtask

  // Behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_trial = 0; m_code = 0; m_bit = 0;
      m_busy = 0; m_done = 0; m_prev = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (!(m_trial <= level)) m_trial = m_trial & ~(1 << m_bit);
        if (m_bit == 0) begin
          m_busy = 0; m_done = 1; m_code = m_trial;
        end else begin
          m_trial = m_trial | (1 << (m_bit - 1));
          m_bit--;
        end
      end else if (start_i && !m_prev) begin
        m_busy = 1; m_trial = 1 << (NB - 1); m_bit = NB - 1;
      end
      m_prev = start_i;
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check("R3 trial", int'(trial_o), m_trial);
      check("R7 code", int'(code_o), m_code);
      check("R8 busy", int'(busy_o), int'(m_busy));
      check("R6 done", int'(done_o), int'(m_done));
    end
    if (cycles > 100000) begin
      n_fails++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic wait_cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    wait_cycles(3);
    check("R1 trial", int'(trial_o), 0);
    check("R1 code", int'(code_o), 0);
    check("R1 busy", int'(busy_o), 0);
    check("R1 done", int'(done_o), 0);
    rst = 1'b0;
    wait_cycles(2);

    // R9: level 5 gives 100, 110, 101 -> 101
    level = 5;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    check("R2 busy after start", int'(busy_o), 1);
    check("R9 first trial", int'(trial_o), 4);
    @(negedge clk);
    check("R9 second trial", int'(trial_o), 6);
    @(negedge clk);
    check("R9 third trial", int'(trial_o), 5);
    @(negedge clk);
    check("R3 done after NB edges", int'(done_o), 1);
    check("R9 result", int'(code_o), 5);
    check("R6 busy low", int'(busy_o), 0);
    @(negedge clk);
    check("R6 done one cycle", int'(done_o), 0);

    // R10: sweep every level
    for (int lv = 0; lv < LEVELS; lv++) begin
      level = lv;
      pulse_start();
      wait_cycles(NB + 1);
      check("R10 sweep result", int'(code_o), lv);
    end

    // R7: result held while inputs change
    level = 2;
    wait_cycles(4);
    check("R7 held result", int'(code_o), LEVELS - 1);

    // R8: start pulses during busy and a held level across the end
    level = 3;
    pulse_start();
    start_i = 1'b1;
    wait_cycles(1);
    start_i = 1'b0;
    wait_cycles(1);
    start_i = 1'b1;
    wait_cycles(NB + 4);
    check("R8 no restart while held", int'(busy_o), 0);
    check("R8 result", int'(code_o), 3);
    start_i = 1'b0;
    wait_cycles(2);

    // R4/R5 extremes: all keep and all drop
    level = LEVELS - 1;
    pulse_start();
    @(negedge clk);
    check("R4 keep path", int'(trial_o), (1 << (NB - 1)) | (1 << (NB - 2)));
    wait_cycles(NB);
    level = 0;
    pulse_start();
    @(negedge clk);
    check("R5 drop path", int'(trial_o), 1 << (NB - 2));
    wait_cycles(NB);
    check("R5 zero result", int'(code_o), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule